// File: doc/BRIEF.md
# Daisy-Chained Slave-Serial Configuration Receiver

This block is the configuration front end of one device in a chain of devices loaded from a single serial stream. An external source drives the configuration clock and presents one bit per rising edge on the serial data input. The block looks for a stream header, reads a length count that tells it how many payload bits belong to it, and absorbs exactly that many. Each completed payload byte is handed out on a parallel bus with a single-cycle strobe. When its share is complete, it raises its done flag.

Every header bit, and every bit that arrives after done, is repeated on the serial data output for the next device. Forwarded bits are re-launched on the falling edge that follows their capture, so the next device can sample them on the following rising edge. An active-low program input restarts the device. After a restart, the block pulls its init status low for a fixed time. It will not start loading until its own hold time has ended and the shared, wired init line reads high, which means every device in the chain is ready. The block only operates when the mode inputs select slave-serial operation.

Top module: `cfg_serial_rx`

## Requirements
- R1: While `prog_n` is sampled low on a rising edge, the block resets. After that edge, `done` and `byte_valid` are 0 and `init_pull` is 1. From the next falling edge on, `dout` is 1.
- R2: After `prog_n` returns high, `init_pull` stays 1 for exactly INIT_HOLD rising edges (default 16) and is 0 after the INIT_HOLD-th edge.
- R3: While `init_pull` is 1 or `init_sense` is 0, `din` is ignored: no header is detected, `done` stays 0, no byte is emitted and `dout` stays 1.
- R4: A stream has three parts, in order. It begins with idle ones. Next comes the 4-bit preamble 0,0,1,0, in arrival order. Last comes a 24-bit length count, sent most significant bit first.
- R5: `din` is sampled on the rising edge of `cfg_clk`. A forwarded bit appears on `dout` at the next falling edge. All header bits (idle ones, preamble and length) are forwarded.
- R6: Payload bits that belong to this device are not forwarded. `dout` stays 1 for them.
- R7: `done` goes to 1 on the rising edge that captures the payload bit whose index equals the length count. If the length is 0, `done` goes to 1 on the edge that captures the last length bit.
- R8: Once `done` is 1, every later `din` bit is forwarded on `dout`, and `done` stays 1 until the next program pulse.
- R9: Payload bits are packed into bytes with the first received bit as bit 7. `byte_valid` is 1 for exactly one cycle after the rising edge that captures the 8th bit of each byte. A trailing partial byte is never emitted.
- R10: When `mode` is not 3'b111, `din` is ignored and the load state is frozen. A bit captured under such a mode is sent on `dout` as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Externally driven configuration clock |
| prog_n | input | 1 | Active-low program/restart, sampled on the rising edge |
| mode | input | 3 | Mode select; 3'b111 selects slave-serial operation |
| din | input | 1 | Serial configuration data in |
| init_sense | input | 1 | Level of the shared wired init line (1 = all devices ready) |
| init_pull | output | 1 | 1 = this device drives the shared init line low |
| dout | output | 1 | Serial data out to the next device, updated on the falling edge |
| done | output | 1 | This device has absorbed its full share of the stream |
| byte_data | output | 8 | Last completed payload byte |
| byte_valid | output | 1 | One-cycle strobe marking a new `byte_data` |

## Verification
The last payload bit can do two things on the same rising edge. It can complete a byte, and it can end the device's share of the stream, so `byte_valid` and `done` rise together. The bench provokes this with a length count that is a multiple of eight and checks both outputs in the sample that follows that edge. The bench also uses a length that is not a multiple of eight. There, `done` must rise while `byte_valid` stays low, and the partial byte must never appear. Right after that edge, the following bit must already be forwarded. This shows that the switch from absorbing to forwarding happens at the exact bit boundary.

// File: rtl/cfg_rx_pkg.sv
// Package: shared types and constants for the serial configuration receiver.
// Assumes: one stream header format (preamble then length, MSB first).
package cfg_rx_pkg;

    typedef enum logic [2:0] {
        ST_WAIT = 3'd0,   // waiting for own hold time and shared init high
        ST_HUNT = 3'd1,   // scanning idle ones for the preamble
        ST_LEN  = 3'd2,   // shifting in the length count
        ST_LOAD = 3'd3,   // absorbing own payload bits
        ST_DONE = 3'd4    // own share complete, pass everything on
    } rx_state_t;

    localparam logic [2:0] MODE_SLAVE   = 3'b111;
    localparam int         PRE_W        = 4;
    localparam logic [3:0] PREAMBLE_PAT = 4'b0010;

endpackage

// File: rtl/cfg_init_ctrl.sv
// Module: cfg_init_ctrl
// Holds the init line low for INIT_HOLD rising edges after a program pulse.
// It then reports when loading may start, which requires the wired line to read high.
// Assumes: prog_n is synchronous to cfg_clk and INIT_HOLD >= 1.
module cfg_init_ctrl #(
    parameter int INIT_HOLD = 16
) (
    input  logic cfg_clk,
    input  logic prog_n,
    input  logic init_sense,
    output logic init_pull,
    output logic load_ok
);
    localparam int CW = $clog2(INIT_HOLD + 1);

    logic [CW-1:0] hold_cnt;

    // Purpose: reload the hold counter on program, then count down to zero.
    always_ff @(posedge cfg_clk) begin
        if (!prog_n) begin
            hold_cnt <= CW'(INIT_HOLD);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    // Purpose: drive the line low during the hold; loading needs every device released.
    always_comb begin
        init_pull = (hold_cnt != '0);
        load_ok   = !init_pull && init_sense;
    end

endmodule

// File: rtl/cfg_header_fsm.sv
// Module: cfg_header_fsm
// Tracks the stream: hunts the preamble, reads the length, then counts own payload bits until done.
// It decides, per bit, whether the bit is passed downstream or absorbed.
// Assumes: the length field is LEN_W bits, MSB first; mode_ok freezes all state when low.
module cfg_header_fsm
    import cfg_rx_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic cfg_clk,
    input  logic prog_n,
    input  logic mode_ok,
    input  logic load_ok,
    input  logic din,
    output logic pass_bit,
    output logic pay_vld,
    output logic done
);
    localparam int LCW = $clog2(LEN_W);

    rx_state_t          state;
    logic [PRE_W-1:0]   win;
    logic [LEN_W-1:0]   len_q;
    logic [LEN_W-1:0]   pcnt;
    logic [LCW-1:0]     lcnt;
    logic [PRE_W-1:0]   win_nx;
    logic [LEN_W-1:0]   len_nx;
    logic [LEN_W-1:0]   pcnt_nx;

    // Purpose: next values of the preamble window, length shift and payload count.
    always_comb begin
        win_nx  = {win[PRE_W-2:0], din};
        len_nx  = {len_q[LEN_W-2:0], din};
        pcnt_nx = pcnt + 1'b1;
    end

    // Purpose: stream state machine, advanced only in slave-serial mode.
    always_ff @(posedge cfg_clk) begin
        if (!prog_n) begin
            state <= ST_WAIT;
            win   <= '1;
            len_q <= '0;
            pcnt  <= '0;
            lcnt  <= '0;
        end else if (mode_ok) begin
            case (state)
                ST_WAIT: begin
                    if (load_ok) begin
                        state <= ST_HUNT;
                        win   <= '1;
                    end
                end
                ST_HUNT: begin
                    win <= win_nx;
                    if (win_nx == PREAMBLE_PAT) begin
                        state <= ST_LEN;
                        lcnt  <= '0;
                    end
                end
                ST_LEN: begin
                    len_q <= len_nx;
                    lcnt  <= lcnt + 1'b1;
                    if (lcnt == LCW'(LEN_W - 1)) begin
                        pcnt  <= '0;
                        state <= (len_nx == '0) ? ST_DONE : ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    pcnt <= pcnt_nx;
                    if (pcnt_nx == len_q) begin
                        state <= ST_DONE;
                    end
                end
                default: state <= ST_DONE;
            endcase
        end
    end

    // Purpose: per-bit routing decisions and the done flag.
    always_comb begin
        pass_bit = mode_ok && (state == ST_HUNT || state == ST_LEN || state == ST_DONE);
        pay_vld  = mode_ok && (state == ST_LOAD);
        done     = (state == ST_DONE);
    end

endmodule

// File: rtl/cfg_byte_pack.sv
// Module: cfg_byte_pack
// Packs absorbed payload bits (first bit into the MSB) and strobes each full byte for one cycle.
// Assumes: bit_vld is high only for bits that belong to this device.
module cfg_byte_pack #(
    parameter int BYTE_W = 8
) (
    input  logic              cfg_clk,
    input  logic              prog_n,
    input  logic              bit_vld,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid
);
    localparam int BCW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nx;
    logic [BCW-1:0]    bcnt;

    // Purpose: next shift value with the new bit entering at the LSB.
    always_comb begin
        shreg_nx = {shreg[BYTE_W-2:0], bit_in};
    end

    // Purpose: shift, count and publish bytes with a one-cycle strobe.
    always_ff @(posedge cfg_clk) begin
        if (!prog_n) begin
            shreg      <= '0;
            bcnt       <= '0;
            byte_data  <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            if (bit_vld) begin
                shreg <= shreg_nx;
                if (bcnt == BCW'(BYTE_W - 1)) begin
                    bcnt       <= '0;
                    byte_data  <= shreg_nx;
                    byte_valid <= 1'b1;
                end else begin
                    bcnt <= bcnt + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/cfg_fwd_stage.sv
// Module: cfg_fwd_stage
// Captures the outgoing bit on the rising edge and launches it on the following falling edge.
// Absorbed or ignored bits are sent as 1.
// Assumes: the next device samples on the rising edge after the launch.
module cfg_fwd_stage (
    input  logic cfg_clk,
    input  logic prog_n,
    input  logic pass_bit,
    input  logic din,
    output logic dout
);
    logic cap_q;

    // Purpose: rising-edge capture of the bit to forward, or an idle 1.
    always_ff @(posedge cfg_clk) begin
        if (!prog_n) begin
            cap_q <= 1'b1;
        end else begin
            cap_q <= pass_bit ? din : 1'b1;
        end
    end

    // Purpose: falling-edge launch, half a period after capture.
    always_ff @(negedge cfg_clk) begin
        if (!prog_n) begin
            dout <= 1'b1;
        end else begin
            dout <= cap_q;
        end
    end

endmodule

// File: rtl/cfg_serial_rx.sv
// Module: cfg_serial_rx (top)
// Slave-serial configuration receiver for one device in a chain.
// It absorbs its own payload, publishes it as bytes and forwards the rest on the falling edge.
// Assumes: cfg_clk is supplied externally; prog_n and mode are synchronous to it.
module cfg_serial_rx
    import cfg_rx_pkg::*;
#(
    parameter int LEN_W     = 24,
    parameter int INIT_HOLD = 16,
    parameter int BYTE_W    = 8
) (
    input  logic              cfg_clk,
    input  logic              prog_n,
    input  logic [2:0]        mode,
    input  logic              din,
    input  logic              init_sense,
    output logic              init_pull,
    output logic              dout,
    output logic              done,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid
);
    logic mode_ok;
    logic load_ok;
    logic pass_bit;
    logic pay_vld;

    // Purpose: slave-serial mode decode.
    always_comb begin
        mode_ok = (mode == MODE_SLAVE);
    end

    cfg_init_ctrl #(.INIT_HOLD(INIT_HOLD)) u_init (
        .cfg_clk    (cfg_clk),
        .prog_n     (prog_n),
        .init_sense (init_sense),
        .init_pull  (init_pull),
        .load_ok    (load_ok)
    );

    cfg_header_fsm #(.LEN_W(LEN_W)) u_fsm (
        .cfg_clk  (cfg_clk),
        .prog_n   (prog_n),
        .mode_ok  (mode_ok),
        .load_ok  (load_ok),
        .din      (din),
        .pass_bit (pass_bit),
        .pay_vld  (pay_vld),
        .done     (done)
    );

    cfg_byte_pack #(.BYTE_W(BYTE_W)) u_pack (
        .cfg_clk    (cfg_clk),
        .prog_n     (prog_n),
        .bit_vld    (pay_vld),
        .bit_in     (din),
        .byte_data  (byte_data),
        .byte_valid (byte_valid)
    );

    cfg_fwd_stage u_fwd (
        .cfg_clk  (cfg_clk),
        .prog_n   (prog_n),
        .pass_bit (pass_bit),
        .din      (din),
        .dout     (dout)
    );

endmodule

// File: rtl/cfg_serial_rx_chk.sv
// Module: cfg_serial_rx_chk
// Port-level temporal checks for cfg_serial_rx, attached with bind.
// Assumes: default parameters with INIT_HOLD >= 1.
module cfg_serial_rx_chk (
    input logic       cfg_clk,
    input logic       prog_n,
    input logic [2:0] mode,
    input logic       init_pull,
    input logic       dout,
    input logic       done,
    input logic       byte_valid
);
    AST_INIT_AFTER_PROG: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        $rose(prog_n) |-> init_pull);                                   // R2
    AST_NO_LOAD_IN_HOLD: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        init_pull |-> (!done && !byte_valid));                          // R3
    AST_DONE_STICKY: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        done |=> done);                                                 // R8
    AST_BYTE_PULSE: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        byte_valid |=> !byte_valid);                                    // R9
    AST_MODE_IDLE_OUT: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (mode != 3'b111) |=> dout);                                     // R10
    AST_MODE_FREEZE: assert property (@(posedge cfg_clk) disable iff (!prog_n)
        (mode != 3'b111) |=> ($stable(done) && !byte_valid));           // R10
endmodule

bind cfg_serial_rx cfg_serial_rx_chk u_chk (
    .cfg_clk    (cfg_clk),
    .prog_n     (prog_n),
    .mode       (mode),
    .init_pull  (init_pull),
    .dout       (dout),
    .done       (done),
    .byte_valid (byte_valid)
);

// File: tb/test_cfg_serial_rx.sv
module test_cfg_serial_rx;
    localparam int LEN_W     = 24;
    localparam int INIT_HOLD = 16;
    localparam int BYTE_W    = 8;

    logic              cfg_clk = 1'b0;
    logic              prog_n  = 1'b0;
    logic [2:0]        mode    = 3'b111;
    logic              din     = 1'b1;
    logic              init_sense = 1'b1;
    logic              init_pull;
    logic              dout;
    logic              done;
    logic [BYTE_W-1:0] byte_data;
    logic              byte_valid;

    int    n_chk  = 0;
    int    n_fail = 0;
    logic  prev_exp = 1'b1;
    logic  have_prev = 1'b0;
    string prev_tag = "R5";
    logic [7:0] got [0:15];
    int    nb = 0;

    always #10 cfg_clk = ~cfg_clk;   // 50 MHz

    cfg_serial_rx #(.LEN_W(LEN_W), .INIT_HOLD(INIT_HOLD), .BYTE_W(BYTE_W)) i_cfg_serial_rx (
        .cfg_clk    (cfg_clk),
        .prog_n     (prog_n),
        .mode       (mode),
        .din        (din),
        .init_sense (init_sense),
        .init_pull  (init_pull),
        .dout       (dout),
        .done       (done),
        .byte_data  (byte_data),
        .byte_valid (byte_valid)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // One bit per period: check the previous bit's dout, drive din, sample after the rising edge.
    task automatic send_bit(input logic b, input logic ef, input string tag);
        @(negedge cfg_clk); #2;
        if (have_prev) check(prev_tag, "dout", {31'd0, dout}, {31'd0, prev_exp});
        din       = b;
        prev_exp  = ef ? b : 1'b1;
        prev_tag  = tag;
        have_prev = 1'b1;
        @(posedge cfg_clk); #2;
        if (byte_valid) begin
            if (nb < 16) got[nb] = byte_data;
            nb++;
        end
    endtask

    task automatic send_header(input int len, input logic ef, input string tag);
        logic [LEN_W-1:0] lv;
        lv = LEN_W'(len);
        for (int i = 0; i < 4; i++) send_bit(1'b1, ef, tag);
        send_bit(1'b0, ef, tag);
        send_bit(1'b0, ef, tag);
        send_bit(1'b1, ef, tag);
        send_bit(1'b0, ef, tag);
        for (int i = LEN_W - 1; i >= 0; i--) send_bit(lv[i], ef, tag);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic ef, input string tag);
        for (int i = 7; i >= 0; i--) send_bit(v[i], ef, tag);
    endtask

    task automatic do_program();
        @(negedge cfg_clk);
        prog_n = 1'b0;
        din    = 1'b1;
        repeat (2) @(posedge cfg_clk);
        @(negedge cfg_clk);
        prog_n = 1'b1;
        repeat (INIT_HOLD + 1) @(posedge cfg_clk);
        #2;
        have_prev = 1'b0;
        nb = 0;
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(posedge cfg_clk);
        #2;
        check("R1", "done in program", {31'd0, done}, 32'd0);
        check("R1", "byte_valid in program", {31'd0, byte_valid}, 32'd0);
        check("R1", "init_pull in program", {31'd0, init_pull}, 32'd1);
        @(negedge cfg_clk); #2;
        check("R1", "dout in program", {31'd0, dout}, 32'd1);
        prog_n = 1'b1;
        n = 0;
        do begin
            @(posedge cfg_clk); #2;
            n++;
        end while (init_pull && n < 100);
        check("R2", "init hold edges", n, INIT_HOLD);
        have_prev = 1'b0;
        nb = 0;
    endtask

    task automatic t_basic();
        do_program();
        send_header(16, 1'b1, "R5");
        send_byte(8'hA5, 1'b0, "R6");
        check("R7", "done mid payload", {31'd0, done}, 32'd0);
        for (int i = 7; i >= 1; i--) send_bit(8'h3C >> i, 1'b0, "R6");
        check("R7", "done before last bit", {31'd0, done}, 32'd0);
        send_bit(1'b0, 1'b0, "R6");
        check("R7", "done at last bit", {31'd0, done}, 32'd1);
        check("R9", "byte_valid with done", {31'd0, byte_valid}, 32'd1);
        send_byte(8'h96, 1'b1, "R8");
        send_bit(1'b1, 1'b1, "R8");
        check("R9", "byte count", nb, 2);
        check("R9", "byte 0", {24'd0, got[0]}, 32'hA5);
        check("R9", "byte 1", {24'd0, got[1]}, 32'h3C);
        check("R8", "done held", {31'd0, done}, 32'd1);
    endtask

    task automatic t_len_zero();
        do_program();
        send_header(0, 1'b1, "R5");
        check("R7", "done after zero length", {31'd0, done}, 32'd1);
        send_byte(8'h5A, 1'b1, "R8");
        send_bit(1'b1, 1'b1, "R8");
        check("R9", "no byte for zero length", nb, 0);
    endtask

    task automatic t_partial();
        do_program();
        send_header(12, 1'b1, "R4");
        send_byte(8'hC3, 1'b0, "R6");
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0, "R6");
        check("R7", "done after 12 bits", {31'd0, done}, 32'd1);
        check("R9", "no strobe for partial", {31'd0, byte_valid}, 32'd0);
        send_byte(8'h81, 1'b1, "R8");
        send_bit(1'b1, 1'b1, "R8");
        check("R9", "partial byte count", nb, 1);
        check("R9", "partial byte 0", {24'd0, got[0]}, 32'hC3);
    endtask

    task automatic t_init_blocked();
        init_sense = 1'b0;
        do_program();
        send_header(8, 1'b0, "R3");
        send_byte(8'h11, 1'b0, "R3");
        send_bit(1'b1, 1'b0, "R3");
        check("R3", "done while blocked", {31'd0, done}, 32'd0);
        check("R3", "bytes while blocked", nb, 0);
        init_sense = 1'b1;
        send_header(8, 1'b1, "R5");
        send_byte(8'h77, 1'b0, "R6");
        check("R3", "done after release", {31'd0, done}, 32'd1);
        check("R3", "byte after release", {24'd0, got[0]}, 32'h77);
    endtask

    task automatic t_mode();
        mode = 3'b011;
        do_program();
        send_header(8, 1'b0, "R10");
        send_byte(8'hFF, 1'b0, "R10");
        check("R10", "done in wrong mode", {31'd0, done}, 32'd0);
        check("R10", "bytes in wrong mode", nb, 0);
        mode = 3'b111;
        send_header(8, 1'b1, "R4");
        send_bit(1'b1, 1'b0, "R6");
        send_bit(1'b0, 1'b0, "R6");
        send_bit(1'b1, 1'b0, "R6");
        send_bit(1'b0, 1'b0, "R6");
        mode = 3'b000;
        send_byte(8'hFF, 1'b0, "R10");
        check("R10", "frozen done", {31'd0, done}, 32'd0);
        mode = 3'b111;
        send_bit(1'b0, 1'b0, "R6");
        send_bit(1'b1, 1'b0, "R6");
        send_bit(1'b1, 1'b0, "R6");
        send_bit(1'b0, 1'b0, "R6");
        check("R10", "done after resume", {31'd0, done}, 32'd1);
        check("R10", "byte count after resume", nb, 1);
        check("R10", "byte after resume", {24'd0, got[0]}, 32'hA6);
    endtask

    initial begin
        #4000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_len_zero();
        t_partial();
        t_init_blocked();
        t_mode();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule